// File: doc/BRIEF.md
# CAN Bus Wake-Pattern Detector

This block watches the dominant/recessive state of a CAN bus while the node sleeps and decides when bus traffic is real enough to wake the host. Every bus phase passes a length filter first. A phase counts only if the bus stays in that state for longer than a programmable number of clock cycles. The detector needs a qualified dominant, then a qualified recessive, then a second qualified dominant. The whole sequence must complete inside a timeout window. Short bursts of bus activity between the qualified phases neither advance nor undo the progress.

When the second dominant qualifies, the block enters wake-request mode. It raises a wake flag that the mode controller uses to move to standby, and it pulls the active-low interrupt and wake-request pins toward the host. From then on, each qualified dominant drives an active-low receive-style wake line low, for the part of the dominant that exceeds the filter time. A request for normal mode or an undervoltage event drops wake-request mode and any pattern in progress.

Top module: `wkp_detect`

## Requirements
- R1: A bus phase (`bus_dom_i` = 1 means dominant, 0 recessive) qualifies only if the bus holds that state for more than FILT_CYC clock cycles; a phase of FILT_CYC cycles or fewer never advances the pattern.
- R2: The wake pattern is a qualified dominant, then a qualified recessive, then a second qualified dominant, in that order.
- R3: Unqualified bus phases while the detector waits for the recessive or for the second dominant do not send it back to the start.
- R4: `wake_flag_o` rises in the cycle after the second dominant qualifies, and `wake_rx_n_o` goes low in the cycle that dominant qualifies.
- R5: While wake-request mode is active, each dominant phase of N cycles (N > FILT_CYC) drives `wake_rx_n_o` low for exactly N − FILT_CYC consecutive cycles. This includes the dominant that completes the pattern.
- R6: `irq_n_o` and `wkrq_n_o` are low exactly while `wake_flag_o` is high.
- R7: The second dominant must qualify within TMO_CYC cycles of the first. Otherwise the pattern is abandoned, and a new pattern is accepted only after a qualified recessive has been seen.
- R8: `normal_req_i` or `uv_i` high at a clock edge clears wake-request mode and any pattern in progress; `wake_flag_o` is low and `irq_n_o`, `wkrq_n_o` are high from the next cycle.
- R9: While `sleep_en_i` is low and wake-request mode is not active, no pattern progresses, `wake_rx_n_o` stays high and `irq_n_o`, `wkrq_n_o` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_dom_i | input | 1 | Sampled bus state, 1 = dominant (asynchronous to clk) |
| sleep_en_i | input | 1 | Low-power sleep active; enables pattern detection |
| normal_req_i | input | 1 | Switch to normal mode; clears wake state |
| uv_i | input | 1 | Undervoltage flag; clears wake state |
| wake_rx_n_o | output | 1 | Active-low wake line, low during qualified dominants in wake-request mode |
| wake_flag_o | output | 1 | Wake-request mode active; requests standby |
| irq_n_o | output | 1 | Active-low host interrupt |
| wkrq_n_o | output | 1 | Active-low wake request to host |

## Verification
If the filter counter or the pattern state is wrong, the block either wakes too early or fails to wake. A wake that is too early shows up as `wake_flag_o` rising after a sequence of short phases, or after a timed-out pattern without a fresh recessive. Either shows within one cycle of the offending qualification. A filter length that is off by one shows in every wake-line pulse, whose width must equal the dominant length minus the filter time. A clear that leaves stale progress shows only later, when a shortened sequence is enough to wake the block. For that reason the checks replay full and partial patterns after each clear.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

   // Progress of the wake-pattern sequencer
   typedef enum logic [2:0] {
      PH_IDLE      = 3'd0,   // waiting for the first qualified dominant
      PH_WAIT_REC  = 3'd1,   // first dominant seen, waiting for a qualified recessive
      PH_WAIT_DOM2 = 3'd2,   // recessive seen, waiting for the second dominant
      PH_WAKE      = 3'd3,   // pattern recognised, wake-request mode
      PH_LOCKOUT   = 3'd4    // timed out, waiting for a qualified recessive
   } wk_phase_t;

endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wkp_filter.sv
module wkp_filter #(
   parameter int FILT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,        // synchronised bus level, 1 = dominant
   output logic dom_lvl_o,    // dominant held beyond the filter time
   output logic dom_evt_o,    // one-cycle pulse: dominant just qualified
   output logic rec_evt_o     // one-cycle pulse: recessive just qualified
);

   localparam int          CW      = $clog2(FILT_CYC + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(FILT_CYC);

   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("wkp_filter: FILT_CYC must be at least 1");
      end
   endgenerate

   logic          lvl_q;
   logic [CW-1:0] run_q;
   logic          dom_q, rec_q;
   logic          dom_c, rec_c;

   // run_q counts cycles since the last change of level, saturating at CNT_TOP
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         run_q <= '0;
      end else begin
         lvl_q <= lvl_i;
         if (lvl_i != lvl_q)      run_q <= '0;
         else if (run_q != CNT_TOP) run_q <= run_q + 1'b1;
      end
   end

   assign dom_c =  lvl_q && (run_q == CNT_TOP);
   assign rec_c = !lvl_q && (run_q == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_q <= 1'b0;
         rec_q <= 1'b0;
      end else begin
         dom_q <= dom_c;
         rec_q <= rec_c;
      end
   end

   assign dom_lvl_o = dom_c;
   assign dom_evt_o = dom_c && !dom_q;
   assign rec_evt_o = rec_c && !rec_q;

   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dom_evt_o && rec_evt_o));                                    // R1
   AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CNT_TOP);                                             // R1
   AST_DOM_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      dom_evt_o |-> $past(lvl_i));                                   // R1

endmodule

// File: rtl/wkp_seq.sv
module wkp_seq
   import wkp_pkg::*;
#(
   parameter int TMO_CYC = 4096
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      dom_evt_i,
   input  logic      rec_evt_i,
   input  logic      sleep_en_i,
   input  logic      clr_i,
   output wk_phase_t phase_o,
   output logic      hit_o        // second dominant qualifies this cycle
);

   localparam int          TW       = $clog2(TMO_CYC + 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

   generate
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("wkp_seq: TMO_CYC must be at least 2");
      end
   endgenerate

   wk_phase_t     st_q, st_d;
   logic [TW-1:0] tmo_q, tmo_d;

   always_comb begin
      st_d  = st_q;
      tmo_d = tmo_q;
      unique case (st_q)
         PH_IDLE: begin
            tmo_d = '0;
            if (dom_evt_i) st_d = PH_WAIT_REC;
         end
         PH_WAIT_REC: begin
            if (tmo_q == TMO_LAST) st_d = PH_LOCKOUT;
            else begin
               tmo_d = tmo_q + 1'b1;
               if (rec_evt_i) st_d = PH_WAIT_DOM2;
            end
         end
         PH_WAIT_DOM2: begin
            if (dom_evt_i)              st_d = PH_WAKE;
            else if (tmo_q == TMO_LAST) st_d = PH_LOCKOUT;
            else                        tmo_d = tmo_q + 1'b1;
         end
         PH_WAKE: st_d = PH_WAKE;
         PH_LOCKOUT: begin
            if (rec_evt_i) st_d = PH_IDLE;
         end
         default: st_d = PH_IDLE;
      endcase
      if (clr_i)                            st_d = PH_IDLE;
      else if (!sleep_en_i && st_q != PH_WAKE) st_d = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PH_IDLE;
         tmo_q <= '0;
      end else begin
         st_q  <= st_d;
         tmo_q <= tmo_d;
      end
   end

   assign phase_o = st_q;
   assign hit_o   = (st_q == PH_WAIT_DOM2) && (st_d == PH_WAKE);

   AST_CLR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> st_q == PH_IDLE);                                    // R8
   AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PH_WAKE && $past(st_q) != PH_WAKE)
         |-> ($past(st_q) == PH_WAIT_DOM2 && $past(dom_evt_i)));     // R4
   AST_TMO_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q <= TMO_LAST);                                            // R7
   AST_NO_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_en_i && st_q != PH_WAKE) |=> st_q == PH_IDLE);         // R9
   AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == PH_LOCKOUT && st_q == PH_IDLE)
         |-> ($past(rec_evt_i) || $past(clr_i) || !$past(sleep_en_i))); // R7

endmodule

// File: rtl/wkp_detect.sv
module wkp_detect
   import wkp_pkg::*;
#(
   parameter int FILT_CYC    = 16,
   parameter int TMO_CYC     = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_dom_i,
   input  logic sleep_en_i,
   input  logic normal_req_i,
   input  logic uv_i,
   output logic wake_rx_n_o,
   output logic wake_flag_o,
   output logic irq_n_o,
   output logic wkrq_n_o
);

   generate
      if (TMO_CYC <= FILT_CYC) begin : g_bad_window
         $error("wkp_detect: TMO_CYC must exceed FILT_CYC");
      end
   endgenerate

   logic      bus_s;
   logic      dom_lvl, dom_evt, rec_evt;
   logic      hit;
   logic      clr;
   wk_phase_t phase;

   assign clr = normal_req_i || uv_i;

   wkp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_dom_i),
      .q_o   (bus_s)
   );

   wkp_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (bus_s),
      .dom_lvl_o (dom_lvl),
      .dom_evt_o (dom_evt),
      .rec_evt_o (rec_evt)
   );

   wkp_seq #(.TMO_CYC(TMO_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .dom_evt_i  (dom_evt),
      .rec_evt_i  (rec_evt),
      .sleep_en_i (sleep_en_i),
      .clr_i      (clr),
      .phase_o    (phase),
      .hit_o      (hit)
   );

   logic wake_mode;
   assign wake_mode   = (phase == PH_WAKE);
   assign wake_rx_n_o = !((wake_mode || hit) && dom_lvl);
   assign wake_flag_o = wake_mode;
   assign irq_n_o     = !wake_mode;
   assign wkrq_n_o    = !wake_mode;

   AST_RX_NEEDS_DOM: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_rx_n_o |-> (dom_lvl && sleep_en_i) || wake_flag_o);       // R5
   AST_FLAG_AFTER_DOM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag_o) |-> $past(dom_lvl) && !$past(clr));         // R4
   AST_HOST_PINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> irq_n_o && wkrq_n_o);                                  // R6

endmodule

// File: tb/wkp_detect_tb_top.sv
`timescale 1ns/1ps
module wkp_detect_tb_top;

   localparam int FILT = 8;
   localparam int TMO  = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_dom = 1'b0;
   logic sleep_en = 1'b1;
   logic normal_req = 1'b0;
   logic uv = 1'b0;
   logic wake_rx_n, wake_flag, irq_n, wkrq_n;

   int total = 0;
   int bad   = 0;
   int exp_q[$];
   bit mon_on = 1'b0;

   always #2.5 clk = ~clk;

   wkp_detect #(.FILT_CYC(FILT), .TMO_CYC(TMO), .SYNC_STAGES(2)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_dom_i    (bus_dom),
      .sleep_en_i   (sleep_en),
      .normal_req_i (normal_req),
      .uv_i         (uv),
      .wake_rx_n_o  (wake_rx_n),
      .wake_flag_o  (wake_flag),
      .irq_n_o      (irq_n),
      .wkrq_n_o     (wkrq_n)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold(bit v, int n);
      bus_dom = v;
      repeat (n) @(negedge clk);
   endtask

   // dominant that should appear on the wake line (R5)
   task automatic dom_seen(int n);
      exp_q.push_back(n - FILT);
      hold(1'b1, n);
   endtask

   task automatic pulse_clear(bit is_uv);
      if (is_uv) uv = 1'b1; else normal_req = 1'b1;
      @(negedge clk);
      uv = 1'b0;
      normal_req = 1'b0;
      @(negedge clk);
   endtask

   // scoreboard monitor: measures each low pulse of the wake line
   int run_len = 0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (!wake_rx_n) run_len++;
         else if (run_len > 0) begin
            if (exp_q.size() == 0) chk("R5 unexpected wake pulse", run_len, 0);
            else chk("R5 wake pulse width", run_len, exp_q.pop_front());
            run_len = 0;
         end
      end
   end

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset irq_n", irq_n, 1);
      chk("R6 reset wkrq_n", wkrq_n, 1);
      chk("R8 reset wake_flag", wake_flag, 0);
      chk("R5 reset wake_rx_n", wake_rx_n, 1);
      mon_on = 1'b1;
      hold(1'b0, 30);

      // R1: phases of exactly FILT cycles never qualify
      hold(1'b1, 8); hold(1'b0, 8); hold(1'b1, 8); hold(1'b0, 8);
      hold(1'b1, 8); hold(1'b0, 20);
      chk("R1 short phases no wake", wake_flag, 0);

      // R2 / R4 / R5 / R6: valid pattern
      hold(1'b1, 12); hold(1'b0, 12);
      dom_seen(15);
      hold(1'b0, 20);
      chk("R4 wake flag after pattern", wake_flag, 1);
      chk("R6 irq_n asserted", irq_n, 0);
      chk("R6 wkrq_n asserted", wkrq_n, 0);
      dom_seen(20);
      hold(1'b0, 20);
      chk("R2 mode held", wake_flag, 1);

      // R8: normal mode request clears wake mode
      pulse_clear(1'b0);
      chk("R8 normal clears flag", wake_flag, 0);
      chk("R8 normal releases irq_n", irq_n, 1);
      hold(1'b1, 20); hold(1'b0, 20);
      chk("R8 no pulse after clear", wake_rx_n, 1);
      pulse_clear(1'b1);
      chk("R8 uv clears progress", wake_flag, 0);

      // R3: glitches between qualified phases keep progress
      hold(1'b1, 12); hold(1'b0, 3); hold(1'b1, 5);
      hold(1'b0, 12); hold(1'b1, 4); hold(1'b0, 5);
      dom_seen(14);
      hold(1'b0, 20);
      chk("R3 wake despite glitches", wake_flag, 1);

      // R8: undervoltage clears wake mode
      pulse_clear(1'b1);
      chk("R8 uv clears flag", wake_flag, 0);
      chk("R8 uv releases wkrq_n", wkrq_n, 1);

      // R7: timeout, then lockout until a qualified recessive
      hold(1'b1, 12); hold(1'b0, 300);
      hold(1'b1, 12); hold(1'b0, 12); hold(1'b1, 12); hold(1'b0, 4);
      chk("R7 lockout blocks pattern", wake_flag, 0);
      hold(1'b0, 10);
      dom_seen(15);
      hold(1'b0, 20);
      chk("R7 recovery after lockout", wake_flag, 1);

      // R9: sleep disabled, no detection
      pulse_clear(1'b1);
      sleep_en = 1'b0;
      hold(1'b1, 12); hold(1'b0, 12); hold(1'b1, 15); hold(1'b0, 20);
      chk("R9 no wake without sleep", wake_flag, 0);
      chk("R9 irq_n idle without sleep", irq_n, 1);
      chk("R9 wake_rx_n idle without sleep", wake_rx_n, 1);

      chk("R5 all expected pulses seen", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule